// File: doc/BRIEF.md
# ADC Conversion Step Sequencer

This block drives a multi-channel successive-approximation converter through a repeating series of conversion steps. A programmable divider derives a converter clock tick from the system clock. Every FSM phase except the conversion wait is measured in these ticks. The sequencer visits the channels set in a mask in ascending index order. For each channel it runs a one-tick setup, an open-delay wait and a sample window. It then issues a one-cycle start-of-conversion pulse and waits for the converter's end-of-conversion strobe. The strobe comes with a 12-bit data word.

A step may average a power-of-two number of conversions. The finished step is delivered as a one-cycle valid pulse, carrying the averaged data and a 4-bit channel tag. In continuous mode the pass over the mask repeats with no gap. In one-shot mode a single pass is made. The sample rate therefore follows from the divider, the delays, the averaging count and the number of enabled channels.

The FSM states are IDLE, SETUP, OPEN, SAMPLE, CONV and HOLD. The transitions are:
- IDLE→SETUP when enable is high and the mask is not empty.
- SETUP→OPEN on a tick, or SETUP→SAMPLE on a tick when the open delay is zero.
- OPEN→SAMPLE after the open-delay ticks.
- SAMPLE→CONV after the sample ticks, with the start-of-conversion pulse.
- CONV→SETUP on end-of-conversion, when more conversions remain or a next channel follows.
- CONV→IDLE on the last conversion of a step when enable is low or nothing remains in continuous mode.
- CONV→HOLD at the end of a one-shot pass.
- HOLD→IDLE when enable falls.

Top module: `adc_step_seq`

## Requirements
- R1: After reset `conv_soc` and `res_valid` are low and the sequencer is idle.
- R2: Each conversion runs, in converter ticks, 1 setup tick, `open_dly` open ticks and `samp_dly` sample ticks. A `samp_dly` of 0 acts as 1. Then `conv_soc` is high for exactly one system cycle. `conv_eoc` is accepted on any system cycle while waiting.
- R3: A converter tick occurs every `clkdiv`+1 system cycles. The tick phase restarts when a conversion's setup begins. With a converter answering 13 ticks after `conv_soc`, one conversion takes (`clkdiv`+1)·(14 + `open_dly` + max(`samp_dly`,1)) system cycles.
- R4: With `clkdiv`=0, `open_dly`=0, `samp_dly`=1, no averaging and one channel, a result appears every 15 system cycles.
- R5: An averaging field n performs 2^n conversions per step, and the result is their sum shifted right by n. Field values above 4 act as 4.
- R6: Enabled channels (mask bit i = channel i) are converted in ascending index order. Each result is a one-cycle `res_valid` pulse with `res_chan` = channel index, registered on the edge that accepts the step's last `conv_eoc`.
- R7: In continuous mode, the lowest enabled channel's setup starts on the same edge that delivers the highest channel's result.
- R8: With `continuous` low, one pass over the mask is made. After it, no further `conv_soc` or result occurs until `enable` is lowered.
- R9: Clearing `enable` lets the current step finish, with all its averaged conversions and its result, and then returns to IDLE.
- R10: With an empty mask the sequencer stays idle and issues no `conv_soc`.
- R11: `conv_eoc` outside the conversion wait is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request |
| continuous | input | 1 | 1: repeat passes; 0: one pass |
| chan_mask | input | 8 | Enabled channels, bit i = channel i |
| clkdiv | input | 8 | Converter tick divider minus one |
| open_dly | input | 8 | Open-delay ticks per conversion |
| samp_dly | input | 8 | Sample-window ticks (0 treated as 1) |
| avg_sel | input | 3 | Averaging exponent (above 4 acts as 4) |
| conv_soc | output | 1 | Start-of-conversion pulse |
| conv_eoc | input | 1 | End-of-conversion strobe |
| conv_data | input | 12 | Converter data, valid with `conv_eoc` |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Averaged result |
| res_chan | output | 4 | Channel tag of the result |

## Verification
Every conversion within a run takes the same time, T = (`clkdiv`+1)·(14 + `open_dly` + max(`samp_dly`,1)). The j-th result of a run that enable starts at edge S is therefore due exactly on edge S + j·T·2^n. The bench's converter model answers 13·(`clkdiv`+1) cycles after each start pulse. The reference model queues each due cycle together with its channel and averaged value. At every falling edge it demands a pulse exactly on the queued cycles and silence on all others. Conversion counts taken after runs show that a stopped, one-shot or empty-mask sequencer issues no extra start pulses.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_OPEN,
        ST_SAMPLE,
        ST_CONV,
        ST_HOLD
    } seq_state_e;
endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] clkdiv,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt == clkdiv);

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // R3: a timed phase run always begins on a fresh tick phase
    p_phase_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0));
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW-1:0]  cur,
    output logic [CW-1:0]  first,
    output logic [CW-1:0]  nxt,
    output logic           has_next,
    output logic           any
);
    always_comb begin
        first    = '0;
        nxt      = '0;
        has_next = 1'b0;
        any      = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                first = CW'(i);
                any   = 1'b1;
                if (i > int'(cur)) begin
                    nxt      = CW'(i);
                    has_next = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc #(
    parameter int DW     = 12,
    parameter int MAXAVG = 4,
    parameter int AVGW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add,
    input  logic            clear,
    input  logic [DW-1:0]   din,
    input  logic [AVGW-1:0] shift,
    output logic [DW-1:0]   result
);
    localparam int AW = DW + MAXAVG;

    logic [AW-1:0] sum;
    logic [AW-1:0] total;

    assign total  = sum + AW'(din);
    assign result = DW'(total >> shift);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) sum <= '0;
        else if (add)        sum <= total;
    end
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DW     = 12,
    parameter int DIVW   = 8,
    parameter int DLYW   = 8,
    parameter int AVGW   = 3,
    parameter int MAXAVG = 4,
    parameter int IDW    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            continuous,
    input  logic [NCH-1:0]  chan_mask,
    input  logic [DIVW-1:0] clkdiv,
    input  logic [DLYW-1:0] open_dly,
    input  logic [DLYW-1:0] samp_dly,
    input  logic [AVGW-1:0] avg_sel,
    output logic            conv_soc,
    input  logic            conv_eoc,
    input  logic [DW-1:0]   conv_data,
    output logic            res_valid,
    output logic [DW-1:0]   res_data,
    output logic [IDW-1:0]  res_chan
);
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CCW = MAXAVG + 1;

    seq_state_e      state, st_n;
    logic [CW-1:0]   chan, chan_n;
    logic [DLYW-1:0] ph_cnt, ph_n;
    logic [CCW-1:0]  conv_cnt, conv_n;

    logic            run, tick;
    logic [CW-1:0]   first, nxt;
    logic            has_next, any;
    logic [AVGW-1:0] avg_n;
    logic            conv_last, eoc_take, acc_add, acc_clr, soc_set;
    logic [DLYW:0]   ph_inc;
    logic [DLYW-1:0] samp_len;
    logic            open_done, samp_done;
    logic [DW-1:0]   acc_res;

    assign run       = (state == ST_SETUP) || (state == ST_OPEN) || (state == ST_SAMPLE);
    assign avg_n     = (avg_sel > AVGW'(MAXAVG)) ? AVGW'(MAXAVG) : avg_sel;
    assign conv_last = (conv_cnt == ((CCW'(1) << avg_n) - CCW'(1)));
    assign eoc_take  = (state == ST_CONV) && conv_eoc;
    assign acc_add   = eoc_take && !conv_last;
    assign acc_clr   = eoc_take && conv_last;
    assign ph_inc    = {1'b0, ph_cnt} + 1'b1;
    assign samp_len  = (samp_dly == '0) ? DLYW'(1) : samp_dly;
    assign open_done = (ph_inc == {1'b0, open_dly});
    assign samp_done = (ph_inc == {1'b0, samp_len});
    assign soc_set   = (state == ST_SAMPLE) && tick && samp_done;

    adc_tick_div #(.DIVW(DIVW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .clkdiv(clkdiv), .tick(tick)
    );

    adc_chan_pick #(.NCH(NCH), .CW(CW)) u_pick (
        .mask(chan_mask), .cur(chan), .first(first), .nxt(nxt),
        .has_next(has_next), .any(any)
    );

    adc_avg_acc #(.DW(DW), .MAXAVG(MAXAVG), .AVGW(AVGW)) u_acc (
        .clk(clk), .rst_n(rst_n), .add(acc_add), .clear(acc_clr),
        .din(conv_data), .shift(avg_n), .result(acc_res)
    );

    // Next-state decisions
    always_comb begin
        st_n   = state;
        chan_n = chan;
        ph_n   = ph_cnt;
        conv_n = conv_cnt;
        unique case (state)
            ST_IDLE: begin
                if (enable && any) begin
                    st_n   = ST_SETUP;
                    chan_n = first;
                    ph_n   = '0;
                    conv_n = '0;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    ph_n = '0;
                    st_n = (open_dly == '0) ? ST_SAMPLE : ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (tick) begin
                    if (open_done) begin
                        ph_n = '0;
                        st_n = ST_SAMPLE;
                    end else begin
                        ph_n = ph_inc[DLYW-1:0];
                    end
                end
            end
            ST_SAMPLE: begin
                if (tick) begin
                    if (samp_done) begin
                        ph_n = '0;
                        st_n = ST_CONV;
                    end else begin
                        ph_n = ph_inc[DLYW-1:0];
                    end
                end
            end
            ST_CONV: begin
                if (conv_eoc) begin
                    if (!conv_last) begin
                        conv_n = conv_cnt + 1'b1;
                        st_n   = ST_SETUP;
                    end else begin
                        conv_n = '0;
                        if (!enable) begin
                            st_n = ST_IDLE;
                        end else if (has_next) begin
                            chan_n = nxt;
                            st_n   = ST_SETUP;
                        end else if (continuous && any) begin
                            chan_n = first;
                            st_n   = ST_SETUP;
                        end else if (continuous) begin
                            st_n = ST_IDLE;
                        end else begin
                            st_n = ST_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (!enable) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            chan     <= '0;
            ph_cnt   <= '0;
            conv_cnt <= '0;
        end else begin
            state    <= st_n;
            chan     <= chan_n;
            ph_cnt   <= ph_n;
            conv_cnt <= conv_n;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_soc  <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_chan  <= '0;
        end else begin
            conv_soc  <= soc_set;
            res_valid <= acc_clr;
            if (acc_clr) begin
                res_data <= acc_res;
                res_chan <= IDW'(chan);
            end
        end
    end

    p_soc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_soc |=> !conv_soc);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_valid_from_conv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(state == ST_CONV));

    p_hold_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && enable) |=> (state == ST_HOLD));

    p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !enable) |=> (state == ST_IDLE && !conv_soc));

    p_empty_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && chan_mask == '0) |=> (state == ST_IDLE));
endmodule

// File: tb/tb_adc_step_seq.sv
module tb_adc_step_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable, continuous;
    logic [7:0]  chan_mask, clkdiv, open_dly, samp_dly;
    logic [2:0]  avg_sel;
    logic        conv_soc, conv_eoc, res_valid;
    logic [11:0] conv_data, res_data;
    logic [3:0]  res_chan;
    logic        model_eoc, spur_eoc;

    always #4 clk = ~clk;

    assign conv_eoc = model_eoc | spur_eoc;

    adc_step_seq dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .continuous(continuous),
        .chan_mask(chan_mask), .clkdiv(clkdiv), .open_dly(open_dly),
        .samp_dly(samp_dly), .avg_sel(avg_sel), .conv_soc(conv_soc),
        .conv_eoc(conv_eoc), .conv_data(conv_data), .res_valid(res_valid),
        .res_data(res_data), .res_chan(res_chan)
    );

    typedef struct {int cyc; int ch; int dat;} exp_t;
    exp_t  q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    exp_k = 0;
    int    kconv = 0;
    int    nsoc = 0;
    int    mD = 1;
    int    rem = 0;
    bit    pend = 0;
    bit    live = 0;
    bit    done = 0;
    string tag = "R1";

    function automatic int cdata(int k);
        return (k * 613 + 29) % 4096;
    endfunction

    function automatic int next_ch(logic [7:0] m, int cur);
        for (int i = cur + 1; i < 8; i++) if (m[i]) return i;
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic chk(bit ok, string t, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual %0d expected %0d", t, what, cyc, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: answers 13 converter clocks after each start pulse
    always @(negedge clk) begin
        model_eoc = 1'b0;
        if (rst_n) begin
            if (conv_soc) begin
                nsoc++;
                rem  = 13 * mD - 1;
                pend = 1;
            end else if (pend) begin
                rem--;
                if (rem == 0) begin
                    model_eoc = 1'b1;
                    conv_data = 12'(cdata(kconv));
                    kconv++;
                    pend = 0;
                end
            end
        end
    end

    // Reference comparison on every cycle
    always @(negedge clk) begin
        if (live) begin
            if (q.size() > 0 && q[0].cyc == cyc) begin
                chk(res_valid == 1'b1, tag, "valid", int'(res_valid), 1);
                chk(int'(res_chan) == q[0].ch, tag, "chan", int'(res_chan), q[0].ch);
                chk(int'(res_data) == q[0].dat, tag, "data", int'(res_data), q[0].dat);
                void'(q.pop_front());
            end else begin
                chk(res_valid == 1'b0, tag, "stray valid", int'(res_valid), 0);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog cycle %0d actual running expected finished", cyc);
            summary();
        end
    end

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic gen(int s, int t, int n, logic [7:0] m, int an);
        int ch = -1;
        for (int j = 1; j <= n; j++) begin
            int sum = 0;
            ch = next_ch(m, ch);
            for (int c = 0; c < (1 << an); c++) begin
                sum += cdata(exp_k);
                exp_k++;
            end
            q.push_back('{s + j * t, ch, sum >> an});
        end
    endtask

    function automatic int step_len(int cd, int od, int sd, int an);
        int sl = (sd == 0) ? 1 : sd;
        return (cd + 1) * (14 + od + sl) * (1 << an);
    endfunction

    task automatic setup(logic [7:0] m, int cd, int od, int sd, int av, bit cont);
        @(negedge clk);
        chan_mask  = m;
        clkdiv     = 8'(cd);
        open_dly   = 8'(od);
        samp_dly   = 8'(sd);
        avg_sel    = 3'(av);
        continuous = cont;
        mD         = cd + 1;
    endtask

    // Continuous run of n steps; enable dropped halfway through the last step
    task automatic run_cont(logic [7:0] m, int cd, int od, int sd, int av, int n, string t);
        int an = (av > 4) ? 4 : av;
        int tl, s, k0;
        setup(m, cd, od, sd, av, 1'b1);
        tag = t;
        k0 = nsoc;
        tl = step_len(cd, od, sd, an);
        s = cyc + 1;
        enable = 1'b1;
        gen(s, tl, n, m, an);
        wait_until(s + (n - 1) * tl + tl / 2);
        enable = 1'b0;
        wait_until(s + n * tl + 60);
        chk(q.size() == 0, t, "results pending", q.size(), 0);
        // R9: the step in flight completes, nothing after it
        chk(nsoc - k0 == n * (1 << an), "R9", "conversions", nsoc - k0, n * (1 << an));
    endtask

    task automatic run_once(logic [7:0] m, int cd, int od, int sd, int av, string t);
        int an = (av > 4) ? 4 : av;
        int tl, s, k0, n;
        setup(m, cd, od, sd, av, 1'b0);
        tag = t;
        k0 = nsoc;
        n = $countones(m);
        tl = step_len(cd, od, sd, an);
        s = cyc + 1;
        enable = 1'b1;
        gen(s, tl, n, m, an);
        wait_until(s + n * tl + 300);
        chk(q.size() == 0, t, "results pending", q.size(), 0);
        // R8: exactly one pass while enable stays high
        chk(nsoc - k0 == n * (1 << an), "R8", "conversions", nsoc - k0, n * (1 << an));
        enable = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0; continuous = 1'b0; chan_mask = '0;
        clkdiv = '0; open_dly = '0; samp_dly = '0; avg_sel = '0;
        spur_eoc = 1'b0; model_eoc = 1'b0; conv_data = '0;
        repeat (4) @(negedge clk);
        chk(conv_soc == 1'b0, "R1", "soc in reset", int'(conv_soc), 0);
        chk(res_valid == 1'b0, "R1", "valid in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1;
        chk(conv_soc == 1'b0, "R1", "soc after reset", int'(conv_soc), 0);

        // R4 minimum settings, 15-cycle results; R6 tagging; R9 stop
        run_cont(8'h01, 0, 0, 1, 0, 4, "R4 R6 R9");
        // R2 R3 divided tick with open delay, R5 pairs, R7 wrap 7 -> 2
        run_cont(8'hA4, 2, 2, 3, 1, 5, "R2 R3 R5 R6 R7");
        // R8 one pass, R2 zero sample delay acting as one, R5 four conversions
        run_once(8'h16, 1, 0, 0, 2, "R2 R5 R8");

        // R10 empty mask and R11 stray end-of-conversion strobes
        begin
            int k0;
            setup(8'h00, 0, 0, 1, 0, 1'b1);
            tag = "R10 R11";
            k0 = nsoc;
            enable = 1'b1;
            for (int p = 0; p < 5; p++) begin
                repeat (20) @(negedge clk);
                spur_eoc = 1'b1;
                @(negedge clk);
                spur_eoc = 1'b0;
            end
            repeat (50) @(negedge clk);
            chk(nsoc == k0, "R10", "soc with empty mask", nsoc - k0, 0);
            enable = 1'b0;
            repeat (5) @(negedge clk);
        end

        // R5 clamp (field 7 acts as 4), R2 long sample window
        run_cont(8'h08, 0, 0, 255, 7, 2, "R2 R5");

        live = 0;
        summary();
    end
endmodule